// File: doc/BRIEF.md
# I2C Channel-Select Target

This block is an I2C target that holds one 8-bit selection register. Each register bit drives one downstream channel-enable output. The block samples the bus lines on a fast system clock and recognises START and STOP conditions. It compares the address byte against its own 7-bit address and acknowledges a match.

On a write, every data byte the controller sends is staged and acknowledged. The staged value reaches the enable outputs only when the bus shows a STOP. A write that several bytes long keeps the final byte. A read shifts out the selection currently in force. It keeps sending that value while the controller acknowledges, and it lets go of the data line when the controller declines.

The address has a fixed upper part given by a parameter and a low 3-bit part taken from strap inputs. This lets several copies share one bus. An active-low asynchronous reset returns everything to the idle, all-off state.

Top module: `i2c_chansel_reg`

## Requirements
- R1: While `rst_n` is low, without any clock edge, `chan_en` reads 0x00 and `sda_oe` reads 0. Any value that was staged but not yet applied is lost, so a later STOP does not apply it.
- R2: The target address is `{ADDR_BASE[6:3], addr_strap}`. Address bytes are sent MSB first, and bit 0 of the byte selects the direction (0 = write, 1 = read). On a matching address byte, the block holds SDA low through the following (ninth) SCL high phase.
- R3: On an address byte that does not match, SDA is left released during the ninth clock. Later bytes of the same transaction are not acknowledged, and `chan_en` is unchanged after the STOP.
- R4: Each data byte of a write to the matching address is acknowledged by SDA held low during its ninth clock.
- R5: After the STOP that ends a write, `chan_en[n]` equals bit n of the last written byte. Any pattern is allowed, including all ones and all zeros.
- R6: `chan_en` does not change while bytes are being received. It changes only after a STOP.
- R7: When several data bytes are written in one transaction, only the last byte reaches `chan_en`.
- R8: A read returns the applied selection MSB first, with SDA changing only while SCL is low. A controller ACK gets the value again. After a controller NACK, SDA stays released.
- R9: A repeated START before a STOP discards the staged byte and returns the block to address reception. A read that follows returns the old selection.
- R10: A transaction that writes no data byte (a read, or an address-only write) leaves `chan_en` unchanged at its STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_strap | input | 3 | Low three bits of the target address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| chan_en | output | NCH | Applied channel enables, bit n to channel n |

## Verification
The bench drives the bus bit by bit and compares `chan_en` against a queue-based model on every clock. This catches a design that updates the outputs at the ninth clock instead of at the STOP. It writes bursts of several bytes, which catches a register that keeps the first byte rather than the last. It places a repeated START after a staged byte, which exposes a block that commits stale data. It sends addresses that differ only in the strap bits, which shows a design that acknowledges the wrong address or keeps listening after a mismatch. It pulses reset mid-transaction, which reveals a staged value that survives reset. Read-back with ACK and then NACK shows a shifter that keeps driving the line or returns the wrong value.

// File: rtl/i2c_chansel_pkg.sv
package i2c_chansel_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ADR_W  = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WRB,
      ST_WACK,
      ST_RDB,
      ST_RACK,
      ST_SKIP
   } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] lines_i,
   output logic [1:0] lines_o
);
   logic [1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= 2'b11;
         else if (g == 0) chain[g] <= lines_i;
         else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
   end

   assign lines_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_p,
   output logic stop_p,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign start_p  = scl_q & scl_s & sda_q & ~sda_s;
   assign stop_p   = scl_q & scl_s & ~sda_q & sda_s;
   assign scl_rise = ~scl_q & scl_s;
   assign scl_fall = scl_q & ~scl_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
   import i2c_chansel_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic [ADR_W-1:0]  dev_addr,
   input  logic [BYTE_W-1:0] rd_val,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte
);
   tgt_state_e        state;
   logic [2:0]        cnt;
   logic              full, rw, nack;
   logic [BYTE_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         full   <= 1'b0;
         rw     <= 1'b0;
         nack   <= 1'b0;
         shreg  <= '0;
         sda_oe <= 1'b0;
         wr_stb <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (start_p) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            full   <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_p) begin
            state  <= ST_IDLE;
            full   <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WRB: begin
                  if (scl_rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 3'd1;
                     full  <= (cnt == 3'd7);
                  end else if (scl_fall && full) begin
                     full <= 1'b0;
                     cnt  <= '0;
                     if (state == ST_WRB) begin
                        sda_oe <= 1'b1;
                        wr_stb <= 1'b1;
                        state  <= ST_WACK;
                     end else if (shreg[BYTE_W-1:1] == dev_addr) begin
                        sda_oe <= 1'b1;
                        rw     <= shreg[0];
                        state  <= ST_AACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     shreg  <= rd_val;
                     sda_oe <= ~rd_val[BYTE_W-1];
                     state  <= ST_RDB;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_WRB;
                  end
               end
               ST_WACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_WRB;
               end
               ST_RDB: if (scl_fall) begin
                  cnt <= cnt + 3'd1;
                  if (cnt == 3'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else begin
                     shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~shreg[BYTE_W-2];
                  end
               end
               ST_RACK: begin
                  if (scl_rise) nack <= sda_s;
                  else if (scl_fall) begin
                     if (nack) state <= ST_SKIP;
                     else begin
                        shreg  <= rd_val;
                        sda_oe <= ~rd_val[BYTE_W-1];
                        cnt    <= '0;
                        state  <= ST_RDB;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign wr_byte = shreg;

   assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);
   assert_byte_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> sda_oe);
   assert_drive_on_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_fall && !start_p && !stop_p) |=> $stable(sda_oe));
   assert_restart_to_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> (state == ST_ADDR));
endmodule

// File: rtl/i2c_chansel_hold.sv
module i2c_chansel_hold
   import i2c_chansel_pkg::*;
#(
   parameter int unsigned NCH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              discard,
   input  logic              commit,
   output logic [NCH-1:0]    chan_en,
   output logic [BYTE_W-1:0] rd_val
);
   logic [NCH-1:0] staged;
   logic           vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged  <= '0;
         vld     <= 1'b0;
         chan_en <= '0;
      end else if (discard) begin
         vld <= 1'b0;
      end else if (commit) begin
         if (vld) chan_en <= staged;
         vld <= 1'b0;
      end else if (wr_stb) begin
         staged <= wr_byte[NCH-1:0];
         vld    <= 1'b1;
      end
   end

   if (NCH < BYTE_W) begin : g_pad
      assign rd_val = {{(BYTE_W-NCH){1'b0}}, chan_en};
   end else begin : g_full
      assign rd_val = chan_en;
   end

   assert_apply_only_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(chan_en));
   assert_restart_keeps_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      discard |=> $stable(chan_en));
endmodule

// File: rtl/i2c_chansel_reg.sv
module i2c_chansel_reg
   import i2c_chansel_pkg::*;
#(
   parameter logic [6:0]  ADDR_BASE   = 7'h70,
   parameter int unsigned NCH         = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           scl_i,
   input  logic           sda_i,
   input  logic [2:0]     addr_strap,
   output logic           sda_oe,
   output logic [NCH-1:0] chan_en
);
   if (NCH < 1 || NCH > BYTE_W) begin : g_bad_nch
      $error("NCH must be between 1 and 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0]        lines_s;
   logic              start_p, stop_p, scl_rise, scl_fall, wr_stb;
   logic [BYTE_W-1:0] wr_byte, rd_val;
   logic [ADR_W-1:0]  dev_addr;

   assign dev_addr = {ADDR_BASE[6:3], addr_strap};

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .lines_i({scl_i, sda_i}), .lines_o(lines_s));

   i2c_bus_events u_evt (
      .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
      .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall));

   i2c_target_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(lines_s[0]),
      .dev_addr(dev_addr), .rd_val(rd_val), .sda_oe(sda_oe),
      .wr_stb(wr_stb), .wr_byte(wr_byte));

   i2c_chansel_hold #(.NCH(NCH)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .discard(start_p), .commit(stop_p), .chan_en(chan_en), .rd_val(rd_val));
endmodule

// File: tb/i2c_chansel_reg_tb.sv
module i2c_chansel_reg_tb;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       tb_low = 1'b0;
   logic [2:0] strap = 3'b010;
   wire        sda_oe;
   wire [7:0]  chan_en;
   wire        sda_bus = ~(tb_low | sda_oe);

   always #4 clk = ~clk;

   i2c_chansel_reg u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .addr_strap(strap), .sda_oe(sda_oe), .chan_en(chan_en));

   int         compared = 0, mismatched = 0;
   logic [7:0] exp_en = 8'h00;
   logic [7:0] stage_q[$];
   bit         settle = 1'b1;
   string      cur_req = "R6";

   task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk)
      if (rst_n && !settle) check(cur_req, chan_en, exp_en, "chan_en per-clock");

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      tb_low = 1'b1; wait_q();
      scl = 1'b0;    wait_q();
   endtask

   task automatic bus_restart();
      tb_low = 1'b0; wait_q();
      scl = 1'b1;    wait_q();
      tb_low = 1'b1; wait_q();
      scl = 1'b0;    wait_q();
      stage_q.delete();
   endtask

   task automatic bus_stop();
      tb_low = 1'b1; wait_q();
      scl = 1'b1;    wait_q();
      settle = 1'b1;
      tb_low = 1'b0; wait_q();
      if (stage_q.size() > 0) exp_en = stage_q[$];
      stage_q.delete();
      settle = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      tb_low = ~b; wait_q();
      scl = 1'b1;  wait_q();
      scl = 1'b0;  wait_q();
   endtask

   task automatic recv_bit(output logic b);
      tb_low = 1'b0; wait_q();
      scl = 1'b1;    repeat (Q/2) @(negedge clk);
      b = sda_bus;   repeat (Q/2) @(negedge clk);
      scl = 1'b0;    wait_q();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(a);
      acked = ~a;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) recv_bit(v[i]);
      send_bit(~mack);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic       ak;
      logic [7:0] rv;
      repeat (5) @(negedge clk);
      check("R1", chan_en, 8'h00, "chan_en in reset");
      check("R1", {7'b0, sda_oe}, 8'h00, "sda_oe in reset");
      rst_n = 1'b1;
      wait_q();
      settle = 1'b0;

      // R2 R4 R5 R6: single byte write, outputs held until STOP
      cur_req = "R6";
      bus_start();
      send_byte(8'hE4, ak); check("R2", {7'b0, ak}, 8'h01, "address ack");
      send_byte(8'hA5, ak); check("R4", {7'b0, ak}, 8'h01, "data ack");
      stage_q.push_back(8'hA5);
      wait_q();
      check("R6", chan_en, 8'h00, "before STOP");
      bus_stop();
      check("R5", chan_en, 8'hA5, "after STOP");

      // R7: burst keeps last byte
      bus_start();
      send_byte(8'hE4, ak);
      for (int i = 0; i < 3; i++) begin
         logic [7:0] d;
         d = (i == 0) ? 8'h01 : (i == 1) ? 8'h3C : 8'h81;
         send_byte(d, ak); check("R4", {7'b0, ak}, 8'h01, "burst ack");
         stage_q.push_back(d);
      end
      bus_stop();
      check("R7", chan_en, 8'h81, "burst last byte");

      // R3: strap mismatch
      bus_start();
      send_byte(8'hE8, ak); check("R3", {7'b0, ak}, 8'h00, "foreign address nack");
      send_byte(8'h55, ak); check("R3", {7'b0, ak}, 8'h00, "ignored data nack");
      bus_stop();
      check("R3", chan_en, 8'h81, "foreign write ignored");

      // R8 R10: read back with ACK then NACK
      bus_start();
      send_byte(8'hE5, ak); check("R2", {7'b0, ak}, 8'h01, "read address ack");
      recv_byte(1'b1, rv); check("R8", rv, 8'h81, "read byte 1");
      recv_byte(1'b0, rv); check("R8", rv, 8'h81, "read byte 2");
      wait_q();
      check("R8", {7'b0, sda_oe}, 8'h00, "released after nack");
      bus_stop();
      check("R10", chan_en, 8'h81, "read leaves enables");

      // R10: address-only write
      bus_start();
      send_byte(8'hE4, ak);
      bus_stop();
      check("R10", chan_en, 8'h81, "address-only write");

      // R9: repeated start drops staged byte
      cur_req = "R9";
      bus_start();
      send_byte(8'hE4, ak);
      send_byte(8'h0F, ak);
      stage_q.push_back(8'h0F);
      bus_restart();
      send_byte(8'hE5, ak); check("R9", {7'b0, ak}, 8'h01, "address after restart");
      recv_byte(1'b0, rv); check("R9", rv, 8'h81, "old value after restart");
      bus_stop();
      check("R9", chan_en, 8'h81, "staged byte dropped");

      // R2 R5: new strap, all-ones and all-zeros
      cur_req = "R5";
      strap = 3'b101;
      wait_q();
      bus_start();
      send_byte(8'hE4, ak); check("R2", {7'b0, ak}, 8'h00, "old address now foreign");
      bus_stop();
      bus_start();
      send_byte(8'hEA, ak); check("R2", {7'b0, ak}, 8'h01, "new strap address ack");
      send_byte(8'hFF, ak); stage_q.push_back(8'hFF);
      bus_stop();
      check("R5", chan_en, 8'hFF, "all channels");
      bus_start();
      send_byte(8'hEA, ak);
      send_byte(8'h00, ak); stage_q.push_back(8'h00);
      bus_stop();
      check("R5", chan_en, 8'h00, "no channels");

      // R1: asynchronous reset mid-transaction
      cur_req = "R1";
      bus_start();
      send_byte(8'hEA, ak);
      send_byte(8'h3C, ak); stage_q.push_back(8'h3C);
      bus_stop();
      bus_start();
      send_byte(8'hEA, ak);
      send_byte(8'hC3, ak);
      settle = 1'b1;
      rst_n = 1'b0;
      #1;
      check("R1", chan_en, 8'h00, "async clear");
      check("R1", {7'b0, sda_oe}, 8'h00, "async release");
      stage_q.delete();
      exp_en = 8'h00;
      scl = 1'b1; wait_q();
      tb_low = 1'b0; wait_q();
      rst_n = 1'b1;
      wait_q();
      settle = 1'b0;
      wait_q();
      check("R1", chan_en, 8'h00, "staged value lost");
      bus_start();
      send_byte(8'hEA, ak);
      send_byte(8'h5A, ak); stage_q.push_back(8'h5A);
      bus_stop();
      check("R5", chan_en, 8'h5A, "write after reset");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule